// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps the interrupt state of one processor core across 256 vectors. Three bitmaps of one bit per vector record what is waiting, what is being serviced and which vectors were raised as level-sensitive. An 8-bit task priority is set by software, and a processor priority is derived from it. Together these decide whether the core is offered an interrupt and, if so, which vector.

Requesters present a vector and its trigger mode. The block says in the same cycle whether the request was taken. The core sees an available flag and a vector. It takes the vector with a one-cycle acknowledge and later retires it with an end-of-interrupt strobe. When the retired vector was level-sensitive, a one-cycle broadcast carrying that vector is emitted so that the source can re-evaluate its line. The task priority can be written whole, or through a 4-bit class port that covers only its upper nibble.

Top module: `vec_prio_ctrl`

## Requirements
- R1: After reset all three bitmaps and the task priority are zero, so `ppr` is 0x00, `int_avail` is 0 and `cls_rdata` is 0.
- R2: An accepted request sets its pending bit. `int_vec` shows the highest pending vector, where vector v is bitmap bit v. The search crosses 32-bit word boundaries correctly, including at vector 0xFF.
- R3: `int_avail` is 1 only when some vector is pending and that vector with its low nibble cleared is strictly greater than `ppr`.
- R4: `ppr` equals the task priority when the task priority's bits 7:4 are at least bits 7:4 of the highest in-service vector. Otherwise it equals that vector with bits 3:0 cleared. An empty in-service set counts as vector 0.
- R5: `ack` while `int_avail` is 1 moves `int_vec` from pending to in service. The new state is visible from the next cycle. `ack` while `int_avail` is 0 has no effect.
- R6: `eoi` clears only the highest in-service vector. An `eoi` with nothing in service changes nothing.
- R7: When the vector retired by `eoi` was requested level-sensitive (`req_level`=1), `leoi_valid` is 1 for exactly the next cycle and `leoi_vec` holds that vector. That vector's trigger bit is then cleared. An edge-requested vector produces no pulse.
- R8: `req_accepted` is 1 only when the vector was not already pending. A level request for a pending vector leaves all state unchanged. An edge request for a pending vector only marks that vector as edge-sensitive.
- R9: While `glb_en` or `sw_en` is 0, requests are dropped: `req_accepted` is 0 and no state changes.
- R10: Requests naming vectors 0x00 to 0x0F are dropped with `req_accepted` 0.
- R11: A `cls_we` write stores `cls_wdata` into task priority bits 7:4 and clears bits 3:0. `cls_rdata` always returns task priority bits 7:4. When `tpr_we` and `cls_we` are both 1, `tpr_we` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global enable |
| sw_en | input | 1 | Software enable |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-sensitive request, 0 = edge |
| req_accepted | output | 1 | Request created a new pending bit (same cycle) |
| ack | input | 1 | Core takes the offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Full task priority write |
| tpr_wdata | input | 8 | Task priority value |
| cls_we | input | 1 | Class-only task priority write |
| cls_wdata | input | 4 | Class value for bits 7:4 |
| cls_rdata | output | 4 | Task priority bits 7:4 |
| ppr | output | 8 | Processor priority |
| int_avail | output | 1 | A deliverable vector is offered |
| int_vec | output | 8 | Highest pending vector |
| leoi_valid | output | 1 | Level end-of-interrupt broadcast pulse |
| leoi_vec | output | 8 | Vector carried by the broadcast |

## Verification
The assertions hold some rules on every cycle. An offered vector always outranks `ppr`, and `ppr` never falls below the task priority class. Every broadcast follows an end-of-interrupt. Taking a vector lifts the priority to at least that vector's class, and a request is only taken when enabled and non-reserved. Only the bench scenarios can show the rest. These are the exact choice among several pending and nested in-service vectors, whether a duplicate request is discarded or re-marked, and the absence of a broadcast for edge vectors. A scoreboard matches broadcasts against the expected vector order.

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl #(
  parameter int NVEC  = 256,
  parameter int WORD  = 32,
  parameter int RSVD  = 16,
  localparam int VW   = $clog2(NVEC),
  localparam int CW   = VW - 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          glb_en,
  input  logic          sw_en,
  input  logic          req_valid,
  input  logic [VW-1:0] req_vec,
  input  logic          req_level,
  output logic          req_accepted,
  input  logic          ack,
  input  logic          eoi,
  input  logic          tpr_we,
  input  logic [VW-1:0] tpr_wdata,
  input  logic          cls_we,
  input  logic [CW-1:0] cls_wdata,
  output logic [CW-1:0] cls_rdata,
  output logic [VW-1:0] ppr,
  output logic          int_avail,
  output logic [VW-1:0] int_vec,
  output logic          leoi_valid,
  output logic [VW-1:0] leoi_vec
);
  localparam int NWORD = NVEC / WORD;
  localparam int WSW   = $clog2(WORD);

  logic [NVEC-1:0] irr_q, isr_q, tmr_q;
  logic [NVEC-1:0] irr_d, isr_d, tmr_d;
  logic [VW-1:0]   tpr_q;

  function automatic logic [VW:0] find_top(input logic [NVEC-1:0] bm);
    logic [NWORD-1:0] nz;
    logic [WORD-1:0]  w;
    logic [VW-1:0]    wsel;
    logic [WSW-1:0]   bsel;
    logic             any;
    for (int i = 0; i < NWORD; i++) nz[i] = |bm[i*WORD +: WORD];
    any  = |nz;
    wsel = '0;
    for (int i = 0; i < NWORD; i++) if (nz[i]) wsel = VW'(i);
    w    = bm[wsel*WORD +: WORD];
    bsel = '0;
    for (int b = 0; b < WORD; b++) if (w[b]) bsel = WSW'(b);
    return {any, VW'(wsel * WORD) | VW'(bsel)};
  endfunction

  logic [VW:0]   irr_top, isr_top;
  logic [VW-1:0] isr_v;
  logic          enabled, req_ok, tmr_wr, ack_take, eoi_take;

  assign irr_top = find_top(irr_q);
  assign isr_top = find_top(isr_q);
  assign isr_v   = isr_top[VW] ? isr_top[VW-1:0] : '0;

  assign ppr       = (tpr_q[VW-1:4] >= isr_v[VW-1:4]) ? tpr_q : {isr_v[VW-1:4], 4'h0};
  assign int_vec   = irr_top[VW-1:0];
  assign int_avail = irr_top[VW] && ({irr_top[VW-1:4], 4'h0} > ppr);
  assign cls_rdata = tpr_q[VW-1:4];

  assign enabled      = glb_en && sw_en;
  assign req_ok       = req_valid && enabled && (int'(req_vec) >= RSVD);
  assign req_accepted = req_ok && !irr_q[req_vec];
  assign tmr_wr       = req_ok && !(req_level && irr_q[req_vec]);
  assign ack_take     = ack && int_avail;
  assign eoi_take     = eoi && isr_top[VW];

  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (ack_take) begin
      irr_d[int_vec] = 1'b0;
      isr_d[int_vec] = 1'b1;
    end
    if (eoi_take) begin
      isr_d[isr_top[VW-1:0]] = 1'b0;
      tmr_d[isr_top[VW-1:0]] = 1'b0;
    end
    if (req_ok) irr_d[req_vec] = 1'b1;
    if (tmr_wr) tmr_d[req_vec] = req_level;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q      <= '0;
      isr_q      <= '0;
      tmr_q      <= '0;
      tpr_q      <= '0;
      leoi_valid <= 1'b0;
      leoi_vec   <= '0;
    end else begin
      irr_q      <= irr_d;
      isr_q      <= isr_d;
      tmr_q      <= tmr_d;
      if (tpr_we)      tpr_q <= tpr_wdata;
      else if (cls_we) tpr_q <= {cls_wdata, 4'h0};
      leoi_valid <= eoi_take && tmr_q[isr_top[VW-1:0]];
      leoi_vec   <= isr_top[VW-1:0];
    end
  end
endmodule

// File: rtl/vec_prio_ctrl_chk.sv
module vec_prio_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       glb_en,
  input logic       sw_en,
  input logic [7:0] req_vec,
  input logic       req_accepted,
  input logic       ack,
  input logic       eoi,
  input logic [3:0] cls_rdata,
  input logic [7:0] ppr,
  input logic       int_avail,
  input logic [7:0] int_vec,
  input logic       leoi_valid
);
  // R3
  offer_above_ppr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_avail |-> ({int_vec[7:4], 4'h0} > ppr));
  // R4
  ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ppr[7:4] >= cls_rdata);
  // R7
  leoi_after_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leoi_valid |-> $past(eoi));
  // R5
  ack_lifts_ppr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_avail) |=> (ppr[7:4] >= $past(int_vec[7:4])));
  // R9
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_accepted |-> (glb_en && sw_en));
  // R10
  req_not_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_accepted |-> (req_vec >= 8'h10));
endmodule

bind vec_prio_ctrl vec_prio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .sw_en(sw_en),
  .req_vec(req_vec), .req_accepted(req_accepted), .ack(ack), .eoi(eoi),
  .cls_rdata(cls_rdata), .ppr(ppr), .int_avail(int_avail),
  .int_vec(int_vec), .leoi_valid(leoi_valid)
);

// File: tb/vec_prio_ctrl_bench.sv
module vec_prio_ctrl_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, glb_en = 1'b0, sw_en = 1'b0;
  logic req_valid = 1'b0, req_level = 1'b0, ack = 1'b0, eoi = 1'b0;
  logic [7:0] req_vec = '0, tpr_wdata = '0;
  logic tpr_we = 1'b0, cls_we = 1'b0;
  logic [3:0] cls_wdata = '0, cls_rdata;
  logic req_accepted, int_avail, leoi_valid;
  logic [7:0] ppr, int_vec, leoi_vec;

  vec_prio_ctrl u_vec_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .sw_en(sw_en),
    .req_valid(req_valid), .req_vec(req_vec), .req_level(req_level),
    .req_accepted(req_accepted), .ack(ack), .eoi(eoi),
    .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .cls_we(cls_we),
    .cls_wdata(cls_wdata), .cls_rdata(cls_rdata), .ppr(ppr),
    .int_avail(int_avail), .int_vec(int_vec),
    .leoi_valid(leoi_valid), .leoi_vec(leoi_vec)
  );

  int errs = 0, checks = 0;
  logic [7:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] v, input logic lvl, input logic acc, input string tag);
    req_valid = 1'b1; req_vec = v; req_level = lvl;
    #1 chk(req_accepted == acc, tag, req_accepted, acc);
    step();
    req_valid = 1'b0;
  endtask

  task automatic set_tpr(input logic [7:0] v);
    tpr_we = 1'b1; tpr_wdata = v;
    step();
    tpr_we = 1'b0;
  endtask

  task automatic take();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  task automatic retire(input bit expect_pulse, input logic [7:0] v);
    if (expect_pulse) exp_q.push_back(v);
    eoi = 1'b1;
    step();
    eoi = 1'b0;
  endtask

  task automatic look(input logic av, input logic [7:0] v, input logic [7:0] p, input string tag);
    chk(int_avail == av, {tag, " avail"}, int_avail, av);
    if (av) chk(int_vec == v, {tag, " vec"}, int_vec, v);
    chk(ppr == p, {tag, " ppr"}, ppr, p);
  endtask

  // scoreboard monitor for level EOI broadcasts (R7)
  always @(negedge clk) begin
    if (rst_n && leoi_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected broadcast", leoi_vec, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(leoi_vec == e, "R7 broadcast vector", leoi_vec, e);
      end
    end
  end

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    look(1'b0, 8'h00, 8'h00, "R1 reset");
    chk(cls_rdata == 4'h0, "R1 cls", cls_rdata, 0);
    glb_en = 1'b1; sw_en = 1'b1;

    send(8'h40, 1'b0, 1'b1, "R2 accept 40");
    look(1'b1, 8'h40, 8'h00, "R2 single");
    send(8'h45, 1'b1, 1'b1, "R2 accept 45");
    send(8'h45, 1'b1, 1'b0, "R8 level duplicate");
    send(8'h40, 1'b0, 1'b0, "R8 edge duplicate");
    send(8'h30, 1'b0, 1'b1, "R2 accept 30");
    look(1'b1, 8'h45, 8'h00, "R2 highest");

    set_tpr(8'h45);
    look(1'b0, 8'h45, 8'h45, "R3 equal class blocked");
    set_tpr(8'h3F);
    look(1'b1, 8'h45, 8'h3F, "R3 above ppr");
    set_tpr(8'h00);

    take();
    look(1'b0, 8'h40, 8'h40, "R5 ack 45");
    set_tpr(8'h50);
    look(1'b0, 8'h40, 8'h50, "R4 task wins");
    set_tpr(8'h30);
    look(1'b0, 8'h40, 8'h40, "R4 in-service wins");

    retire(1'b1, 8'h45);
    look(1'b1, 8'h40, 8'h30, "R6 retire 45");
    take();
    look(1'b0, 8'h30, 8'h40, "R5 ack 40");
    retire(1'b0, 8'h40);
    look(1'b0, 8'h30, 8'h30, "R7 edge no pulse");

    set_tpr(8'h00);
    look(1'b1, 8'h30, 8'h00, "R3 30 offered");
    retire(1'b0, 8'h00);
    look(1'b1, 8'h30, 8'h00, "R6 empty eoi");
    ack = 1'b1; tpr_we = 1'b0;
    step();
    ack = 1'b0;
    look(1'b0, 8'h00, 8'h30, "R5 ack 30");

    send(8'h80, 1'b1, 1'b1, "R2 accept 80");
    look(1'b1, 8'h80, 8'h30, "R3 80 offered");
    take();
    look(1'b0, 8'h00, 8'h80, "R5 nested ack");
    retire(1'b1, 8'h80);
    look(1'b0, 8'h00, 8'h30, "R6 highest retired first");
    retire(1'b0, 8'h30);
    look(1'b0, 8'h00, 8'h00, "R6 nest empty");

    send(8'h1F, 1'b0, 1'b1, "R2 accept 1F");
    send(8'h20, 1'b0, 1'b1, "R2 accept 20");
    look(1'b1, 8'h20, 8'h00, "R2 word boundary");
    send(8'hFF, 1'b1, 1'b1, "R2 accept FF");
    look(1'b1, 8'hFF, 8'h00, "R2 top vector");
    take();
    retire(1'b1, 8'hFF);
    look(1'b1, 8'h20, 8'h00, "R7 after FF");

    sw_en = 1'b0;
    send(8'h60, 1'b0, 1'b0, "R9 sw disabled");
    sw_en = 1'b1; glb_en = 1'b0;
    send(8'h61, 1'b0, 1'b0, "R9 global disabled");
    glb_en = 1'b1;
    look(1'b1, 8'h20, 8'h00, "R9 no state change");

    send(8'h0F, 1'b0, 1'b0, "R10 reserved");
    look(1'b1, 8'h20, 8'h00, "R10 no state change");

    ack = 1'b1;
    req_valid = 1'b0;
    cls_we = 1'b1; cls_wdata = 4'hA;
    ack = 1'b0;
    step();
    cls_we = 1'b0;
    chk(cls_rdata == 4'hA, "R11 class read", cls_rdata, 4'hA);
    look(1'b0, 8'h20, 8'hA0, "R11 class write");

    tpr_we = 1'b1; tpr_wdata = 8'h12; cls_we = 1'b1; cls_wdata = 4'h7;
    step();
    tpr_we = 1'b0; cls_we = 1'b0;
    look(1'b1, 8'h20, 8'h12, "R11 full write wins");

    repeat (2) step();
    chk(exp_q.size() == 0, "R7 missing broadcast", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule